// File: doc/BRIEF.md
# TLB Access Rights and Fault Checker

This block sits after a translation lookaside buffer lookup and decides whether one memory access may go ahead. It takes the lookup result (hit flag, entry valid flag, physical page number, access identifier, two privilege levels, a three-bit rights type and the dirty, break and reference-trap flags), the privilege of the requester, the access kind, a physical-mode flag, a protection-enable flag and a set of protection-ID registers. It returns the physical address, a read/write/execute permission mask and a single prioritized fault code.

All of the evaluation is combinational. The address, mask and fault code are captured in one output register stage whenever `req_valid` is high, and `rsp_valid` marks the cycle in which they appear. The translation storage and the recording of faulting addresses belong to neighbouring blocks.

Top module: `tlb_perm_check`

## Requirements
- R1: With `phys_mode` high, `pa` equals `va` (zero-extended or truncated to `PA_W`), `perm` is 3'b111 and `fault` is 0, whatever the entry fields hold.
- R2: With `phys_mode` low and either `ent_hit` or `ent_valid` low, `pa` and `perm` are 0 and `fault` is 1 (instruction miss) for an execute access and 2 (data miss) for every other kind.
- R3: For a valid entry, the privilege grants read when `priv` <= `ent_pl1`, write when `priv` <= `ent_pl2`, and execute when `ent_pl2` <= `priv` <= `ent_pl1`. `perm` bit 0 is read, bit 1 is write and bit 2 is execute.
- R4: `ent_type` 0 keeps only read, 1 read and write, 2 read and execute, 3 all three, and 4 to 7 only execute, each ANDed with the R3 grants.
- R5: When `prot_en` is high, `ent_aid` is nonzero and {`ent_aid`,1'b1} equals any protection-ID register, write is cleared from `perm`. A write access then reports fault 3 (protection-ID) and skips the checks of R7 and R8.
- R6: Access kind 0 (none) reports fault 0 on a valid entry, and its mask is not reduced by the dirty, break or reference flags. Kind encoding: 0 none, 1 read, 2 write, 3 execute.
- R7: When the mask after R3 to R5 lacks the bit of the access kind, the fault is 4 (instruction protection) for execute and 5 (data access rights) for read or write. The mask is reported as it stands.
- R8: After R7 passes: a clear dirty flag removes write and gives fault 6 on a write; a set break flag removes write and gives fault 7 on a write; a set reference-trap flag keeps only execute and gives fault 8 on any non-execute access. These are applied in that order and a later fault replaces an earlier one.
- R9: For a valid entry, `pa` is `ent_ppn` above the low `PAGE_BITS` bits of `va`.
- R10: Reset clears `pa`, `perm`, `fault` and `rsp_valid`. `rsp_valid` follows `req_valid` one cycle later, and the outputs change only in the cycle after `req_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Evaluate and capture this cycle's request |
| va | input | VA_W | Virtual address |
| phys_mode | input | 1 | Translation off: direct mapping |
| prot_en | input | 1 | Enable protection-ID comparison |
| priv | input | PL_W | Requester privilege number (0 most privileged) |
| acc_kind | input | 2 | 0 none, 1 read, 2 write, 3 execute |
| ent_hit | input | 1 | Lookup found an entry covering `va` |
| ent_valid | input | 1 | Entry rights have been written |
| ent_ppn | input | PA_W-PAGE_BITS | Physical page number |
| ent_aid | input | AID_W | Access identifier, 0 means public |
| ent_pl1 | input | PL_W | Read / upper execute privilege bound |
| ent_pl2 | input | PL_W | Write / lower execute privilege bound |
| ent_type | input | 3 | Rights type |
| ent_d | input | 1 | Dirty flag |
| ent_b | input | 1 | Break flag |
| ent_t | input | 1 | Reference-trap flag |
| pid_regs | input | N_PID*(AID_W+1) | Protection-ID registers, register i at bits [i*(AID_W+1) +: AID_W+1] |
| rsp_valid | output | 1 | Outputs hold a new result |
| pa | output | PA_W | Physical address |
| perm | output | 3 | Permission mask {execute, write, read} |
| fault | output | 4 | Fault code, 0 means none |

## Verification
The bench builds the block with a 36-bit physical address over a 32-bit virtual address, so physical mode exercises the zero extension, and with a 4-bit access identifier so that random identifiers often match one of the four protection-ID registers and the write-stripping path is hit regularly. Privilege levels stay at two bits, which lets random stimulus cover every ordering of the two bounds, including inverted windows that grant no execute. Directed vectors pin down the override order among the dirty, break and reference faults and the protection-ID fault that pre-empts them.

// File: rtl/tlb_perm_pkg.sv
package tlb_perm_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_kind_e;

  typedef enum logic [3:0] {
    FLT_NONE    = 4'd0,
    FLT_IMISS   = 4'd1,
    FLT_DMISS   = 4'd2,
    FLT_DPID    = 4'd3,
    FLT_IPROT   = 4'd4,
    FLT_DRIGHTS = 4'd5,
    FLT_DIRTY   = 4'd6,
    FLT_BREAK   = 4'd7,
    FLT_PAGEREF = 4'd8
  } fault_e;

  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W = 1;
  localparam int unsigned PERM_X = 2;

endpackage

// File: rtl/tlb_rights_decode.sv
module tlb_rights_decode #(
  parameter int unsigned PL_W = 2
) (
  input  logic [PL_W-1:0] priv,
  input  logic [PL_W-1:0] pl1,
  input  logic [PL_W-1:0] pl2,
  input  logic [2:0]      rtype,
  output logic [2:0]      base_perm
);
  import tlb_perm_pkg::*;

  logic rd_ok, wr_ok, ex_ok;

  always_comb begin
    rd_ok = (priv <= pl1);
    wr_ok = (priv <= pl2);
    ex_ok = (pl2 <= priv) && (priv <= pl1);
  end

  always_comb begin
    base_perm = 3'b000;
    unique case (rtype)
      3'd0: base_perm[PERM_R] = rd_ok;
      3'd1: begin
        base_perm[PERM_R] = rd_ok;
        base_perm[PERM_W] = wr_ok;
      end
      3'd2: begin
        base_perm[PERM_R] = rd_ok;
        base_perm[PERM_X] = ex_ok;
      end
      3'd3: begin
        base_perm[PERM_R] = rd_ok;
        base_perm[PERM_W] = wr_ok;
        base_perm[PERM_X] = ex_ok;
      end
      default: base_perm[PERM_X] = ex_ok;
    endcase
  end

endmodule

// File: rtl/tlb_pid_match.sv
module tlb_pid_match #(
  parameter int unsigned AID_W = 18,
  parameter int unsigned N_PID = 4
) (
  input  logic                         prot_en,
  input  logic [AID_W-1:0]             aid,
  input  logic [N_PID*(AID_W+1)-1:0]   pid_regs,
  output logic                         pid_hit
);
  localparam int unsigned PID_W = AID_W + 1;

  logic [PID_W-1:0] key;
  logic [N_PID-1:0] eq;

  assign key = {aid, 1'b1};

  for (genvar gi = 0; gi < N_PID; gi++) begin : g_cmp
    assign eq[gi] = (pid_regs[gi*PID_W +: PID_W] == key);
  end

  assign pid_hit = prot_en && (|aid) && (|eq);

endmodule

// File: rtl/tlb_fault_prio.sv
module tlb_fault_prio (
  input  logic [1:0] acc_kind,
  input  logic [2:0] base_perm,
  input  logic       pid_hit,
  input  logic       flag_d,
  input  logic       flag_b,
  input  logic       flag_t,
  output logic [2:0] perm_out,
  output logic [3:0] fault_out
);
  import tlb_perm_pkg::*;

  logic need_ok;
  logic is_wr, is_ex;

  assign is_wr = (acc_kind == ACC_WRITE);
  assign is_ex = (acc_kind == ACC_EXEC);

  always_comb begin
    perm_out  = base_perm;
    fault_out = FLT_NONE;
    need_ok   = 1'b1;
    if (pid_hit) perm_out[PERM_W] = 1'b0;
    unique case (acc_kind)
      ACC_READ:  need_ok = perm_out[PERM_R];
      ACC_WRITE: need_ok = perm_out[PERM_W];
      ACC_EXEC:  need_ok = perm_out[PERM_X];
      default:   need_ok = 1'b1;
    endcase
    if (pid_hit && is_wr) begin
      fault_out = FLT_DPID;
    end else if (acc_kind != ACC_NONE) begin
      if (!need_ok) begin
        fault_out = is_ex ? FLT_IPROT : FLT_DRIGHTS;
      end else begin
        if (!flag_d) begin
          if (is_wr) fault_out = FLT_DIRTY;
          perm_out[PERM_W] = 1'b0;
        end
        if (flag_b) begin
          if (is_wr) fault_out = FLT_BREAK;
          perm_out[PERM_W] = 1'b0;
        end
        if (flag_t) begin
          if (!is_ex) fault_out = FLT_PAGEREF;
          perm_out[PERM_R] = 1'b0;
          perm_out[PERM_W] = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned AID_W     = 18,
  parameter int unsigned N_PID     = 4,
  parameter int unsigned PL_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [VA_W-1:0]               va,
  input  logic                          phys_mode,
  input  logic                          prot_en,
  input  logic [PL_W-1:0]               priv,
  input  logic [1:0]                    acc_kind,
  input  logic                          ent_hit,
  input  logic                          ent_valid,
  input  logic [PA_W-PAGE_BITS-1:0]     ent_ppn,
  input  logic [AID_W-1:0]              ent_aid,
  input  logic [PL_W-1:0]               ent_pl1,
  input  logic [PL_W-1:0]               ent_pl2,
  input  logic [2:0]                    ent_type,
  input  logic                          ent_d,
  input  logic                          ent_b,
  input  logic                          ent_t,
  input  logic [N_PID*(AID_W+1)-1:0]    pid_regs,
  output logic                          rsp_valid,
  output logic [PA_W-1:0]               pa,
  output logic [2:0]                    perm,
  output logic [3:0]                    fault
);
  import tlb_perm_pkg::*;

  localparam int unsigned PPN_W = PA_W - PAGE_BITS;

  logic [2:0]      base_perm;
  logic            pid_hit;
  logic [2:0]      chk_perm;
  logic [3:0]      chk_fault;
  logic            entry_ok;
  logic [PA_W-1:0] pa_nxt;
  logic [2:0]      perm_nxt;
  logic [3:0]      fault_nxt;

  tlb_rights_decode #(.PL_W(PL_W)) u_rights (
    .priv      (priv),
    .pl1       (ent_pl1),
    .pl2       (ent_pl2),
    .rtype     (ent_type),
    .base_perm (base_perm)
  );

  tlb_pid_match #(.AID_W(AID_W), .N_PID(N_PID)) u_pid (
    .prot_en  (prot_en),
    .aid      (ent_aid),
    .pid_regs (pid_regs),
    .pid_hit  (pid_hit)
  );

  tlb_fault_prio u_prio (
    .acc_kind  (acc_kind),
    .base_perm (base_perm),
    .pid_hit   (pid_hit),
    .flag_d    (ent_d),
    .flag_b    (ent_b),
    .flag_t    (ent_t),
    .perm_out  (chk_perm),
    .fault_out (chk_fault)
  );

  assign entry_ok = ent_hit && ent_valid;

  always_comb begin
    if (phys_mode) begin
      pa_nxt    = PA_W'(va);
      perm_nxt  = 3'b111;
      fault_nxt = FLT_NONE;
    end else if (!entry_ok) begin
      pa_nxt    = '0;
      perm_nxt  = 3'b000;
      fault_nxt = (acc_kind == ACC_EXEC) ? FLT_IMISS : FLT_DMISS;
    end else begin
      pa_nxt    = {PPN_W'(ent_ppn), va[PAGE_BITS-1:0]};
      perm_nxt  = chk_perm;
      fault_nxt = chk_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      pa        <= '0;
      perm      <= 3'b000;
      fault     <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        pa    <= pa_nxt;
        perm  <= perm_nxt;
        fault <= fault_nxt;
      end
    end
  end

endmodule

// File: rtl/tlb_perm_check_sva.sv
module tlb_perm_check_sva #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned AID_W     = 18,
  parameter int unsigned N_PID     = 4,
  parameter int unsigned PL_W      = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic [VA_W-1:0]               va,
  input logic                          phys_mode,
  input logic [PL_W-1:0]               priv,
  input logic [1:0]                    acc_kind,
  input logic                          ent_hit,
  input logic                          ent_valid,
  input logic [PL_W-1:0]               ent_pl1,
  input logic [PL_W-1:0]               ent_pl2,
  input logic                          rsp_valid,
  input logic [PA_W-1:0]               pa,
  input logic [2:0]                    perm,
  input logic [3:0]                    fault
);

  a_r1_phys_full: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && phys_mode |=> perm == 3'b111 && fault == 4'd0 && pa == PA_W'($past(va)));

  a_r2_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !phys_mode && !(ent_hit && ent_valid) |=>
      perm == 3'b000 && fault == (($past(acc_kind) == 2'd3) ? 4'd1 : 4'd2));

  a_r3_exec_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !phys_mode && ent_hit && ent_valid && acc_kind == 2'd3 &&
    (priv < ent_pl2 || priv > ent_pl1) |=> fault == 4'd4);

  a_r5_pid_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && fault == 4'd3 |-> !perm[1]);

  a_r6_none_clean: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !phys_mode && ent_hit && ent_valid && acc_kind == 2'd0 |=> fault == 4'd0);

  a_r8_ref_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && fault == 4'd8 |-> perm[1:0] == 2'b00);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(pa) && $stable(perm) && $stable(fault) && !rsp_valid);

  a_r10_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

endmodule

bind tlb_perm_check tlb_perm_check_sva #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
  .AID_W(AID_W), .N_PID(N_PID), .PL_W(PL_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .va        (va),
  .phys_mode (phys_mode),
  .priv      (priv),
  .acc_kind  (acc_kind),
  .ent_hit   (ent_hit),
  .ent_valid (ent_valid),
  .ent_pl1   (ent_pl1),
  .ent_pl2   (ent_pl2),
  .rsp_valid (rsp_valid),
  .pa        (pa),
  .perm      (perm),
  .fault     (fault)
);

// File: tb/tlb_perm_check_tb.sv
module tlb_perm_check_tb;

  localparam int unsigned VA_W  = 32;
  localparam int unsigned PA_W  = 36;
  localparam int unsigned PB    = 12;
  localparam int unsigned AID_W = 4;
  localparam int unsigned N_PID = 4;
  localparam int unsigned PL_W  = 2;
  localparam int unsigned PID_W = AID_W + 1;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic                       req_valid = 1'b0;
  logic [VA_W-1:0]            va = '0;
  logic                       phys_mode = 1'b0;
  logic                       prot_en = 1'b0;
  logic [PL_W-1:0]            priv = '0;
  logic [1:0]                 acc_kind = '0;
  logic                       ent_hit = 1'b0;
  logic                       ent_valid = 1'b0;
  logic [PA_W-PB-1:0]         ent_ppn = '0;
  logic [AID_W-1:0]           ent_aid = '0;
  logic [PL_W-1:0]            ent_pl1 = '0;
  logic [PL_W-1:0]            ent_pl2 = '0;
  logic [2:0]                 ent_type = '0;
  logic                       ent_d = 1'b0;
  logic                       ent_b = 1'b0;
  logic                       ent_t = 1'b0;
  logic [N_PID*PID_W-1:0]     pid_regs = '0;
  logic                       rsp_valid;
  logic [PA_W-1:0]            pa;
  logic [2:0]                 perm;
  logic [3:0]                 fault;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [PA_W-1:0] exp_pa = '0;
  logic [2:0]      exp_perm = '0;
  logic [3:0]      exp_fault = '0;
  logic            exp_rv = 1'b0;
  string           exp_tag = "R10";

  always #2 clk = ~clk;

  tlb_perm_check #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB),
    .AID_W(AID_W), .N_PID(N_PID), .PL_W(PL_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
    .phys_mode(phys_mode), .prot_en(prot_en), .priv(priv), .acc_kind(acc_kind),
    .ent_hit(ent_hit), .ent_valid(ent_valid), .ent_ppn(ent_ppn), .ent_aid(ent_aid),
    .ent_pl1(ent_pl1), .ent_pl2(ent_pl2), .ent_type(ent_type), .ent_d(ent_d),
    .ent_b(ent_b), .ent_t(ent_t), .pid_regs(pid_regs),
    .rsp_valid(rsp_valid), .pa(pa), .perm(perm), .fault(fault)
  );

  // Behavioural reference: what the requirements say one request yields.
  task automatic model(output logic [PA_W-1:0] m_pa, output logic [2:0] m_perm,
                       output logic [3:0] m_fault, output string tag);
    bit r, w, x, matched;
    int need;
    m_pa = '0; m_perm = 3'b000; m_fault = 4'd0;
    if (phys_mode) begin
      m_pa = {{(PA_W-VA_W){1'b0}}, va}; m_perm = 3'b111; tag = "R1";
      return;
    end
    if (!(ent_hit && ent_valid)) begin
      m_fault = (acc_kind == 2'd3) ? 4'd1 : 4'd2; tag = "R2";
      return;
    end
    m_pa = {ent_ppn, va[PB-1:0]};
    tag = "R3 R4 R9";
    r = (int'(priv) <= int'(ent_pl1));
    w = (int'(priv) <= int'(ent_pl2));
    x = (int'(ent_pl2) <= int'(priv)) && (int'(priv) <= int'(ent_pl1));
    case (int'(ent_type))
      0: m_perm = {1'b0, 1'b0, r};
      1: m_perm = {1'b0, w, r};
      2: m_perm = {x, 1'b0, r};
      3: m_perm = {x, w, r};
      default: m_perm = {x, 1'b0, 1'b0};
    endcase
    matched = 1'b0;
    for (int i = 0; i < N_PID; i++)
      if (int'(pid_regs[i*PID_W +: PID_W]) == int'(ent_aid) * 2 + 1) matched = 1'b1;
    matched = matched && prot_en && (ent_aid != 0);
    if (matched) begin
      m_perm[1] = 1'b0; tag = "R5";
      if (acc_kind == 2'd2) begin m_fault = 4'd3; return; end
    end
    if (acc_kind == 2'd0) begin tag = "R6"; return; end
    need = int'(acc_kind) - 1;
    if (!m_perm[need]) begin
      m_fault = (acc_kind == 2'd3) ? 4'd4 : 4'd5; tag = "R7";
      return;
    end
    if (!ent_d) begin
      if (acc_kind == 2'd2) m_fault = 4'd6;
      m_perm[1] = 1'b0; tag = "R8";
    end
    if (ent_b) begin
      if (acc_kind == 2'd2) m_fault = 4'd7;
      m_perm[1] = 1'b0; tag = "R8";
    end
    if (ent_t) begin
      if (acc_kind != 2'd3) m_fault = 4'd8;
      m_perm = m_perm & 3'b100; tag = "R8";
    end
  endtask

  // One clock: inputs already driven; result compared at the next falling edge.
  task automatic step();
    logic [PA_W-1:0] n_pa; logic [2:0] n_perm; logic [3:0] n_fault; string n_tag;
    model(n_pa, n_perm, n_fault, n_tag);
    @(posedge clk);
    @(negedge clk);
    exp_rv = req_valid;
    if (req_valid) begin
      exp_pa = n_pa; exp_perm = n_perm; exp_fault = n_fault; exp_tag = n_tag;
    end else begin
      exp_tag = "R10";
    end
    checks++;
    if (rsp_valid !== exp_rv || pa !== exp_pa || perm !== exp_perm || fault !== exp_fault) begin
      errors++;
      $display("FAIL %s: got rv=%0b pa=%h perm=%b fault=%0d, expected rv=%0b pa=%h perm=%b fault=%0d",
               exp_tag, rsp_valid, pa, perm, fault, exp_rv, exp_pa, exp_perm, exp_fault);
    end
  endtask

  task automatic set_entry(input bit hit, input bit vld, input logic [PL_W-1:0] p1,
                           input logic [PL_W-1:0] p2, input logic [2:0] ty,
                           input bit d, input bit b, input bit t);
    ent_hit = hit; ent_valid = vld; ent_pl1 = p1; ent_pl2 = p2;
    ent_type = ty; ent_d = d; ent_b = b; ent_t = t;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (rsp_valid !== 1'b0 || pa !== '0 || perm !== 3'b000 || fault !== 4'd0) begin
      errors++;
      $display("FAIL R10: reset got rv=%0b pa=%h perm=%b fault=%0d, expected all zero",
               rsp_valid, pa, perm, fault);
    end
    rst_n = 1'b1;
    step();

    // R1: physical mode, entry says nothing allowed
    req_valid = 1'b1; phys_mode = 1'b1; va = 32'hDEAD_BEEF; acc_kind = 2'd2;
    set_entry(1, 1, 0, 0, 3'd0, 0, 1, 1);
    step();
    phys_mode = 1'b0;

    // R2: miss for execute and for read; invalid entry on write
    va = 32'h1234_5678; ent_ppn = 24'hABCDEF;
    set_entry(0, 1, 3, 0, 3'd3, 1, 0, 0); acc_kind = 2'd3; step();
    acc_kind = 2'd1; step();
    set_entry(1, 0, 3, 0, 3'd3, 1, 0, 0); acc_kind = 2'd2; step();

    // R3 R4 R9: clean accesses, priv 1 with pl1=2, pl2=1
    priv = 2'd1;
    set_entry(1, 1, 2, 1, 3'd3, 1, 0, 0);
    acc_kind = 2'd1; step();
    acc_kind = 2'd2; step();
    acc_kind = 2'd3; step();
    // R3: execute outside window (priv 0 < pl2) -> R7 instruction protection
    priv = 2'd0; step();
    // R4: type 5 grants execute only; read refused -> R7 data rights
    priv = 2'd1; ent_type = 3'd5; acc_kind = 2'd1; step();

    // R5: protection-ID match removes write; write faults
    ent_type = 3'd3; prot_en = 1'b1; ent_aid = 4'd5;
    pid_regs = {5'd0, 5'd0, 5'd11, 5'd0};
    acc_kind = 2'd2; step();
    acc_kind = 2'd1; step();
    ent_aid = 4'd0; pid_regs = {5'd1, 5'd1, 5'd1, 5'd1}; acc_kind = 2'd2; step();
    prot_en = 1'b0;

    // R6: kind none with all flags set keeps mask
    set_entry(1, 1, 2, 1, 3'd3, 0, 1, 1); acc_kind = 2'd0; step();

    // R8: dirty alone, break overrides dirty, reference overrides break
    set_entry(1, 1, 3, 3, 3'd3, 0, 0, 0); priv = 2'd2; acc_kind = 2'd2; step();
    ent_b = 1'b1; step();
    ent_t = 1'b1; step();
    acc_kind = 2'd3; step();

    // R10: hold while idle
    req_valid = 1'b0; set_entry(0, 0, 0, 0, 3'd0, 0, 0, 0); acc_kind = 2'd3;
    repeat (3) step();

    // Randomised sweep
    for (int n = 0; n < 4000; n++) begin
      req_valid = ($urandom_range(0, 7) != 0);
      phys_mode = ($urandom_range(0, 15) == 0);
      prot_en   = $urandom_range(0, 1);
      priv      = PL_W'($urandom);
      acc_kind  = 2'($urandom);
      va        = $urandom;
      ent_ppn   = (PA_W-PB)'({$urandom, $urandom});
      ent_aid   = AID_W'($urandom);
      set_entry($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                PL_W'($urandom), PL_W'($urandom), 3'($urandom),
                $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
                $urandom_range(0, 3) == 0);
      for (int k = 0; k < N_PID; k++)
        pid_regs[k*PID_W +: PID_W] = PID_W'($urandom);
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule